// File: doc/BRIEF.md
# RC-5 Infrared Frame Receiver

This block turns the demodulated, active-low envelope of an infrared receiver module into decoded RC-5 frames. A frame holds fourteen bi-phase bits: two start bits, a toggle bit, a five-bit address and a six-bit command. Every field is sent most significant bit first. The first half of the first start bit is a space, so it cannot be seen on the line. The receiver therefore starts its timing at the first mark edge, which is the middle of the first start bit. From there it follows the frame by sorting each gap between edges as a half-bit (short) or a full bit (long).

The envelope first passes a two-stage synchroniser and then an edge detector. A free-running interval counter measures the time since the last edge. A small state machine records whether the line is at the middle of a bit or at a boundary between bits. A quarter-bit after each mid-bit edge, the line level is sampled as the bit value. After the fourteenth bit the fields are presented with a one-cycle valid pulse. Any interval that is neither short nor long, or a silence too long in the middle of a frame, aborts the frame with a one-cycle error pulse. After a frame ends or aborts, the receiver waits in idle for the next mark edge.

Timing is expressed in clock cycles through `HALF_CYC`, the length of one half-bit (nominally 889 µs).

Top module: `rc5_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `frame_valid` and `frame_err` are low. The outputs `rx_addr`, `rx_cmd`, `rx_toggle` and `rx_field` reset to zero.
- R2: `ir_n` is active-low (0 = mark). In idle, only a falling edge of `ir_n` starts a frame. That edge is taken as the middle of the first start bit.
- R3: Each bit takes the level of its second half (mark = 1, space = 0). The frame order is start, field, toggle, address[4:0], command[5:0], each field MSB first. The valid pulse comes within `HALF_CYC/2 + SYNC_STAGES + 4` cycles of the last input change.
- R4: The second start bit is reported unchanged on `rx_field`, and the toggle bit is reported on `rx_toggle`.
- R5: An interval of 0.75 to 1.25 half-bits counts as short, and one of 1.5 to 2.5 half-bits counts as long. Frames whose half-bits are scaled by 0.8 or 1.2 decode correctly.
- R6: An interval in neither range aborts the frame. It gives an `frame_err` pulse and no `frame_valid` pulse, and the receiver returns to idle.
- R7: If no edge arrives within `TIMEOUT_CYC` (about 3 ms, i.e. `HALF_CYC*3375/1000`) during a frame, the frame is discarded with one `frame_err` pulse.
- R8: `frame_valid` is a one-cycle pulse after the fourteenth bit. The field outputs change only together with it and hold until the next valid pulse.
- R9: After a completed frame the receiver is idle. The trailing mark-to-space edge causes no error, and a following frame decodes normally.
- R10: `frame_valid` and `frame_err` are never high in the same cycle, and each is high for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_n | input | 1 | Demodulated envelope, low during a mark |
| frame_valid | output | 1 | One-cycle pulse when a frame has been decoded |
| frame_err | output | 1 | One-cycle pulse when a frame is aborted |
| rx_addr | output | 5 | Decoded system address |
| rx_cmd | output | 6 | Decoded command |
| rx_toggle | output | 1 | Decoded toggle bit |
| rx_field | output | 1 | Second start bit (field bit), unchanged |

## Verification
A wrong mid-bit/boundary state or a wrong interval class does not stay hidden. It shows up at the very next edge, either as an error pulse during a clean frame or as a valid pulse whose fields are shifted or inverted. So the fault is visible within one frame time of about 28 half-bits. A sample timer or bit counter that is off by one shows up as a command with its low bit wrong, or as a missing valid pulse. A stuck timeout counter shows up when a truncated frame produces no error pulse within about 3 ms of silence.

// File: rtl/rc5rx_pkg.sv
package rc5rx_pkg;

    localparam int unsigned FRAME_BITS = 14;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned CMD_W      = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MID  = 2'd1,
        ST_BND  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        IV_SHORT = 2'd0,
        IV_LONG  = 2'd1,
        IV_BAD   = 2'd2
    } ivl_e;

    typedef struct packed {
        logic              field;
        logic              toggle;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } rc5_frame_t;

    // Sort an edge-to-edge gap of k cycles against a half-bit of h cycles.
    function automatic ivl_e classify(input int unsigned k, input int unsigned h);
        if (k * 4 >= h * 3 && k * 4 <= h * 5)
            return IV_SHORT;
        else if (k * 4 >= h * 6 && k * 4 <= h * 10)
            return IV_LONG;
        else
            return IV_BAD;
    endfunction

endpackage

// File: rtl/rc5rx_edge.sv
module rc5rx_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ir_n,
    output logic mark,
    output logic edge_p
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            mark_q <= 1'b0;
        end else begin
            chain  <= {chain[SYNC_STAGES-2:0], ir_n};
            mark_q <= mark;
        end
    end

    assign mark   = ~chain[SYNC_STAGES-1];
    assign edge_p = mark ^ mark_q;
endmodule

// File: rtl/rc5rx_interval.sv
module rc5rx_interval
    import rc5rx_pkg::*;
#(
    parameter int unsigned HALF_CYC    = 32,
    parameter int unsigned TIMEOUT_CYC = 108,
    localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_p,
    output ivl_e cls,
    output logic timeout
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (edge_p)
            cnt <= CNT_W'(1);
        else if (cnt != '1)
            cnt <= cnt + CNT_W'(1);
    end

    assign cls     = classify(32'(cnt), HALF_CYC);
    assign timeout = (cnt >= CNT_W'(TIMEOUT_CYC));
endmodule

// File: rtl/rc5rx_frame.sv
module rc5rx_frame
    import rc5rx_pkg::*;
#(
    parameter int unsigned SAMPLE_DLY = 16,
    localparam int unsigned SC_W      = $clog2(SAMPLE_DLY + 1),
    localparam int unsigned BC_W      = $clog2(FRAME_BITS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mark,
    input  logic       edge_p,
    input  ivl_e       cls,
    input  logic       timeout,
    output logic       valid,
    output logic       err,
    output rc5_frame_t frame
);
    rx_state_e             state;
    logic                  armed;
    logic [SC_W-1:0]       scnt;
    logic [BC_W-1:0]       bitcnt;
    logic [FRAME_BITS-3:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            armed  <= 1'b0;
            scnt   <= '0;
            bitcnt <= '0;
            shreg  <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
            frame  <= '0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (armed && scnt != '0)
                scnt <= scnt - SC_W'(1);
            case (state)
                ST_IDLE: begin
                    if (edge_p && mark) begin
                        state  <= ST_MID;
                        bitcnt <= '0;
                        armed  <= 1'b1;
                        scnt   <= SC_W'(SAMPLE_DLY - 1);
                    end
                end
                default: begin
                    if (edge_p) begin
                        if (state == ST_MID && cls == IV_SHORT) begin
                            state <= ST_BND;
                        end else if ((state == ST_BND && cls == IV_SHORT) ||
                                     (state == ST_MID && cls == IV_LONG)) begin
                            state <= ST_MID;
                            armed <= 1'b1;
                            scnt  <= SC_W'(SAMPLE_DLY - 1);
                        end else begin
                            state <= ST_IDLE;
                            armed <= 1'b0;
                            err   <= 1'b1;
                        end
                    end else if (timeout) begin
                        state <= ST_IDLE;
                        armed <= 1'b0;
                        err   <= 1'b1;
                    end else if (armed && scnt == '0) begin
                        armed <= 1'b0;
                        shreg <= {shreg[FRAME_BITS-4:0], mark};
                        if (bitcnt == BC_W'(FRAME_BITS - 1)) begin
                            state        <= ST_IDLE;
                            valid        <= 1'b1;
                            frame.field  <= shreg[11];
                            frame.toggle <= shreg[10];
                            frame.addr   <= shreg[9:5];
                            frame.cmd    <= {shreg[4:0], mark};
                        end else begin
                            bitcnt <= bitcnt + BC_W'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rc5_rx.sv
module rc5_rx
    import rc5rx_pkg::*;
#(
    parameter int unsigned HALF_CYC    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ir_n,
    output logic              frame_valid,
    output logic              frame_err,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [CMD_W-1:0]  rx_cmd,
    output logic              rx_toggle,
    output logic              rx_field
);
    localparam int unsigned TIMEOUT_CYC = (HALF_CYC * 3375) / 1000;
    localparam int unsigned SAMPLE_DLY  = HALF_CYC / 2;

    logic       mark;
    logic       edge_p;
    ivl_e       cls;
    logic       timeout;
    rc5_frame_t frame;

    rc5rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .ir_n   (ir_n),
        .mark   (mark),
        .edge_p (edge_p)
    );

    rc5rx_interval #(.HALF_CYC(HALF_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ivl (
        .clk     (clk),
        .rst     (rst),
        .edge_p  (edge_p),
        .cls     (cls),
        .timeout (timeout)
    );

    rc5rx_frame #(.SAMPLE_DLY(SAMPLE_DLY)) u_frm (
        .clk     (clk),
        .rst     (rst),
        .mark    (mark),
        .edge_p  (edge_p),
        .cls     (cls),
        .timeout (timeout),
        .valid   (frame_valid),
        .err     (frame_err),
        .frame   (frame)
    );

    assign rx_addr   = frame.addr;
    assign rx_cmd    = frame.cmd;
    assign rx_toggle = frame.toggle;
    assign rx_field  = frame.field;
endmodule

// File: rtl/rc5_rx_chk.sv
module rc5_rx_chk #(
    parameter int unsigned HALF_CYC    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       ir_n,
    input logic       frame_valid,
    input logic       frame_err,
    input logic [4:0] rx_addr,
    input logic [5:0] rx_cmd,
    input logic       rx_toggle,
    input logic       rx_field
);
    localparam int unsigned TIMEOUT_CYC = (HALF_CYC * 3375) / 1000;
    localparam int unsigned VALID_WIN   = HALF_CYC / 2 + SYNC_STAGES + 4;
    localparam int unsigned ERR_WIN     = TIMEOUT_CYC + SYNC_STAGES + 4;
    localparam int unsigned Q_W         = $clog2(ERR_WIN + 4) + 1;

    logic           ir_q;
    logic [Q_W-1:0] quiet;

    // Cycles since the raw envelope last changed.
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= 1'b1;
            quiet <= '0;
        end else begin
            ir_q <= ir_n;
            if (ir_n != ir_q)
                quiet <= '0;
            else if (quiet != '1)
                quiet <= quiet + Q_W'(1);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!frame_valid && !frame_err));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_err));

    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    a_r8_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable({rx_field, rx_toggle, rx_addr, rx_cmd}));

    a_r3_valid_near_edge: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (quiet <= Q_W'(VALID_WIN)));

    a_r7_err_bounded: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> (quiet <= Q_W'(ERR_WIN)));
endmodule

bind rc5_rx rc5_rx_chk #(.HALF_CYC(HALF_CYC), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ir_n        (ir_n),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .rx_addr     (rx_addr),
    .rx_cmd      (rx_cmd),
    .rx_toggle   (rx_toggle),
    .rx_field    (rx_field)
);

// File: tb/rc5_rx_tb.sv
module rc5_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 32;
    localparam int GAP        = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_n = 1'b1;
    logic       frame_valid, frame_err;
    logic [4:0] rx_addr;
    logic [5:0] rx_cmd;
    logic       rx_toggle, rx_field;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt = 0;
    int ecnt = 0;
    int wide = 0;
    int both = 0;
    logic prev_v = 1'b0;
    logic prev_e = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc5_rx #(.HALF_CYC(HALF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .ir_n(ir_n),
        .frame_valid(frame_valid), .frame_err(frame_err),
        .rx_addr(rx_addr), .rx_cmd(rx_cmd),
        .rx_toggle(rx_toggle), .rx_field(rx_field)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) vcnt++;
            if (frame_err) ecnt++;
            if ((frame_valid && prev_v) || (frame_err && prev_e)) wide++;
            if (frame_valid && frame_err) both++;
            prev_v = frame_valid;
            prev_e = frame_err;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive nhalf half-bits of a frame, each hl cycles, then idle for gap cycles.
    task automatic send(input logic fld, input logic tog, input logic [4:0] a,
                        input logic [5:0] c, input int hl, input int nhalf, input int gap);
        logic [13:0] w;
        logic        b;
        w = {1'b1, fld, tog, a, c};
        for (int i = 0; i < nhalf; i++) begin
            b = w[13 - i/2];
            ir_n = (i % 2 == 0) ? b : ~b;
            repeat (hl) @(negedge clk);
        end
        ir_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic t_good(input logic fld, input logic tog, input logic [4:0] a,
                          input logic [5:0] c, input int hl, input string req);
        int v0, e0;
        v0 = vcnt; e0 = ecnt;
        send(fld, tog, a, c, hl, 28, GAP);
        chk(vcnt == v0 + 1, {req, " one valid"}, vcnt - v0, 1);
        chk(ecnt == e0, {req, " no err"}, ecnt - e0, 0);
        chk(rx_addr == a, {req, " addr R3"}, rx_addr, a);
        chk(rx_cmd == c, {req, " cmd R3"}, rx_cmd, c);
        chk(rx_toggle == tog, {req, " toggle R4"}, rx_toggle, tog);
        chk(rx_field == fld, {req, " field R4"}, rx_field, fld);
    endtask

    task automatic t_reset();
        chk(frame_valid == 1'b0, "R1 valid low", frame_valid, 0);
        chk(frame_err == 1'b0, "R1 err low", frame_err, 0);
        chk({rx_field, rx_toggle, rx_addr, rx_cmd} == 13'd0, "R1 fields zero",
            {rx_field, rx_toggle, rx_addr, rx_cmd}, 0);
    endtask

    task automatic t_back_to_back();
        int v0, e0;
        v0 = vcnt; e0 = ecnt;
        send(1'b1, 1'b1, 5'h00, 6'h3F, HALF, 28, 2 * HALF);
        send(1'b1, 1'b0, 5'h0A, 6'h15, HALF, 28, GAP);
        chk(vcnt == v0 + 2, "R9 two valids", vcnt - v0, 2);
        chk(ecnt == e0, "R9 trailing edge no err", ecnt - e0, 0);
        chk(rx_addr == 5'h0A, "R9 second addr", rx_addr, 5'h0A);
        chk(rx_cmd == 6'h15, "R9 second cmd", rx_cmd, 6'h15);
    endtask

    task automatic t_bad(input int hl);
        int v0, e0;
        logic [12:0] held;
        v0 = vcnt; e0 = ecnt;
        held = {rx_field, rx_toggle, rx_addr, rx_cmd};
        send(1'b1, 1'b1, 5'h1F, 6'h3F, hl, 28, GAP);
        chk(ecnt > e0, "R6 err on bad interval", ecnt - e0, 1);
        chk(vcnt == v0, "R6 no valid", vcnt - v0, 0);
        chk({rx_field, rx_toggle, rx_addr, rx_cmd} == held, "R8 fields held",
            {rx_field, rx_toggle, rx_addr, rx_cmd}, held);
    endtask

    task automatic t_timeout();
        int v0, e0;
        v0 = vcnt; e0 = ecnt;
        send(1'b1, 1'b0, 5'h12, 6'h2D, HALF, 11, GAP);
        chk(ecnt == e0 + 1, "R7 one err on silence", ecnt - e0, 1);
        chk(vcnt == v0, "R7 frame discarded", vcnt - v0, 0);
        // R2: idle after abort, a fresh frame decodes
        t_good(1'b1, 1'b0, 5'h03, 6'h01, HALF, "R2 after abort");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (20) @(negedge clk);
        t_reset();
        t_good(1'b1, 1'b0, 5'h05, 6'h35, HALF, "R2 R3 basic");
        t_good(1'b0, 1'b1, 5'h1F, 6'h00, HALF, "R4 field zero");
        t_good(1'b1, 1'b1, 5'h16, 6'h29, (HALF * 8) / 10, "R5 fast");
        t_good(1'b0, 1'b0, 5'h09, 6'h3A, (HALF * 12) / 10, "R5 slow");
        t_back_to_back();
        t_bad((HALF * 6) / 10);
        t_bad((HALF * 14) / 10);
        t_timeout();
        chk(wide == 0, "R8 R10 single-cycle pulses", wide, 0);
        chk(both == 0, "R10 never together", both, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule